// File: doc/BRIEF.md
# Serial Display Read Engine with Dummy-Bit Realignment

This block performs one register read from a display panel attached over a four-wire serial link that carries a separate data/command select line. On an accepted request, it asserts chip select and holds the data/command line low. It then shifts the command byte out, most significant bit first. Within the same chip-select window it goes on clocking and captures the response bytes, again most significant bit first. Those bytes are delivered one at a time with a valid strobe and a last marker.

Two commands need special handling: identification (0x04) and status (0x09). For these, the panel answers with one idle clock before its data. The engine reads one more byte than requested and shifts the whole stream up by one bit, so the caller sees aligned data. These two commands also accept only a length of 3 or 4 bytes. A zero-length request is refused for any command. A refused request produces an error pulse and no link activity.

A read of the power-mode register (0x0A) also updates a held flag that tells whether the panel reports itself as fully on. The serial clock runs at a read rate that is derived from parameters.

Top module: `dbi_read_engine`

## Requirements
- R1: Each serial clock high phase and low phase lasts HALF system cycles. HALF = ceil(SYS_HZ / (2*F)), where F is the lower of READ_CAP_HZ and LINK_MAX_HZ/2.
- R2: While chip select is low, the data/command line is low. The command byte appears on the output line MSB first and is stable on each of the first eight rising clock edges.
- R3: Command bits and response bits share one chip-select window. That window holds exactly 8 + 8*N rising edges, or 8 + 8*(N+1) edges for commands 0x04 and 0x09, where N is the requested length.
- R4: For commands other than 0x04 and 0x09, the N bytes sampled after the command are delivered unchanged and in order. The last marker is set on the final byte only.
- R5: For commands 0x04 and 0x09, output byte i equals (raw[i] << 1) | (raw[i+1] >> 7). The first sampled bit is dropped and exactly N bytes are delivered.
- R6: A request for 0x04 or 0x09 whose length is neither 3 nor 4 raises the error flag in the cycle after it is presented and starts no link activity.
- R7: A zero-length request raises the error flag in the cycle after it is presented and starts no link activity.
- R8: After a 0x0A read, the on flag is 1 exactly when the first response byte, masked with 0x7C (bits 0, 1 and 7 cleared), equals 0x1C. Other reads leave the flag unchanged.
- R9: Busy is high for the whole transaction, and a request presented while busy is ignored. A one-cycle done pulse marks the release of chip select.
- R10: After reset: chip select high, serial clock low, data/command high, busy, valid, error, done and on flag all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_cmd | input | 8 | Command byte to read |
| req_len | input | LEN_W | Number of response bytes wanted |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | Response byte strobe |
| rd_data | output | 8 | Response byte |
| rd_last | output | 1 | Marks the final response byte |
| err | output | 1 | Request refused (one-cycle pulse) |
| done | output | 1 | Transaction finished (one-cycle pulse) |
| disp_on | output | 1 | Panel-on flag from the last power-mode read |
| lnk_cs_n | output | 1 | Chip select, active low |
| lnk_sclk | output | 1 | Serial clock, idle low |
| lnk_dc | output | 1 | Data/command select |
| lnk_mosi | output | 1 | Serial data to the panel |
| lnk_miso | input | 1 | Serial data from the panel |

## Verification
The error pulse and busy are due one cycle after the request is presented. The bench presents requests on a falling clock edge and reads both on the next falling edge. Response bytes are due two cycles after the rising serial edge that captures their final bit, so the bench collects every strobe on falling edges until done arrives and compares the whole sequence afterwards. The on flag is read once done has pulsed, because by then the first byte has long since been delivered. A bench model of the panel times the serial clock phases in nanoseconds against HALF times the 8 ns period. It also counts rising edges per chip-select window and latches the command from the output line.

// File: rtl/dbi_rd_pkg.sv
// Package: shared constants and rate arithmetic for the serial read engine.
// Assumes command codes are 8 bits and the power-mode test uses a fixed mask.
package dbi_rd_pkg;

    localparam logic [7:0] CMD_IDENT   = 8'h04;
    localparam logic [7:0] CMD_STATUS  = 8'h09;
    localparam logic [7:0] CMD_PWRMODE = 8'h0A;
    localparam logic [7:0] PWR_KEEP    = 8'h7C;
    localparam logic [7:0] PWR_ON_VAL  = 8'h1C;

    // System cycles per half period of the read clock (rounded up, at least 1).
    function automatic int unsigned half_cycles(int unsigned sys_hz,
                                                int unsigned link_hz,
                                                int unsigned cap_hz);
        int unsigned rd_hz;
        int unsigned h;
        rd_hz = ((link_hz / 2) < cap_hz) ? (link_hz / 2) : cap_hz;
        if (rd_hz == 0) rd_hz = 1;
        h = (sys_hz + 2 * rd_hz - 1) / (2 * rd_hz);
        return (h == 0) ? 1 : h;
    endfunction

    // True for commands whose reply is preceded by one idle clock.
    function automatic logic is_skewed(logic [7:0] c);
        return (c == CMD_IDENT) || (c == CMD_STATUS);
    endfunction

endpackage

// File: rtl/dbi_rd_clkgen.sv
// Module: half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF cycles while enabled; restarts from zero
// whenever enable drops, so the first tick of a transaction is a full half late.
module dbi_rd_clkgen #(
    parameter int unsigned HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] LAST = HW'(HALF - 1);

    logic [HW-1:0] cnt;

    // Count system cycles within a half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);

endmodule

// File: rtl/dbi_rd_serdes.sv
// Module: bit engine for one read transaction.
// Shifts the command out MSB first, then samples nraw response bytes on rising
// serial edges; mosi changes only on falling edges. Assumes miso is stable
// around each rising edge (the panel drives it on falling edges).
module dbi_rd_serdes #(
    parameter int RAW_W = 5,
    parameter int CNT_W = RAW_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       cmd,
    input  logic [RAW_W-1:0] nraw,
    input  logic             tick,
    input  logic             miso,
    output logic             active,
    output logic             sclk,
    output logic             mosi,
    output logic             byte_stb,
    output logic [7:0]       byte_data,
    output logic             fin
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tot;
    logic [CNT_W-1:0] cnt_nx;
    logic [7:0]       sh_out;
    logic [7:0]       sh_in;

    assign cnt_nx = cnt + 1'b1;

    // Sequence the command and response bits across serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
            sh_out    <= '0;
            sh_in     <= '0;
            cnt       <= '0;
            tot       <= '0;
            byte_stb  <= 1'b0;
            byte_data <= '0;
            fin       <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            fin      <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sclk   <= 1'b0;
                mosi   <= cmd[7];
                sh_out <= {cmd[6:0], 1'b0};
                cnt    <= '0;
                tot    <= CNT_W'(8) + (CNT_W'(nraw) << 3);
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    if (cnt >= CNT_W'(8)) begin
                        sh_in <= {sh_in[6:0], miso};
                        if (cnt[2:0] == 3'd7) begin
                            byte_stb  <= 1'b1;
                            byte_data <= {sh_in[6:0], miso};
                        end
                    end
                end else begin
                    sclk <= 1'b0;
                    if (cnt_nx == tot) begin
                        active <= 1'b0;
                        mosi   <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        cnt    <= cnt_nx;
                        mosi   <= sh_out[7];
                        sh_out <= {sh_out[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R3: the bit index never reaches the window length while active.
    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < tot));
    // R2: clock is idle low whenever no transaction runs.
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);
    // R3: captured bytes only appear inside a window.
    assert_byte_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> active);

endmodule

// File: rtl/dbi_rd_align.sv
// Module: response realignment.
// In skew mode, the first raw byte is only held, and each later raw byte
// emits (held << 1) | (new >> 7); otherwise raw bytes pass through. Marks the
// byte whose index equals len-1 as last. Assumes clr precedes every transaction.
module dbi_rd_align #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             skew,
    input  logic [LEN_W-1:0] len,
    input  logic             in_stb,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last
);
    logic [7:0]       held;
    logic             have_held;
    logic [LEN_W-1:0] n_out;
    logic             emit;
    logic [7:0]       emit_val;

    // Choose whether this raw byte produces an output, and its value.
    always_comb begin
        emit     = in_stb && (!skew || have_held);
        emit_val = skew ? {held[6:0], in_data[7]} : in_data;
    end

    // Hold the previous raw byte and register the emitted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= '0;
            have_held <= 1'b0;
            n_out     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (clr) begin
                have_held <= 1'b0;
                n_out     <= '0;
            end else begin
                if (in_stb) begin
                    held      <= in_data;
                    have_held <= 1'b1;
                end
                if (emit) begin
                    out_valid <= 1'b1;
                    out_data  <= emit_val;
                    out_last  <= (n_out == len - 1'b1);
                    n_out     <= n_out + 1'b1;
                end
            end
        end
    end

    // R4: the last marker never stands without a byte.
    assert_last_has_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: rtl/dbi_rd_ctrl.sv
// Module: request screening and result flags.
// Accepts a request when idle, rejects zero lengths and wrong lengths on
// skewed commands, sets up raw byte count and skew mode, and updates the
// panel-on flag from the first byte of a power-mode read.
module dbi_rd_ctrl
    import dbi_rd_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int RAW_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    input  logic             active,
    input  logic             out_valid,
    input  logic [7:0]       out_data,
    output logic             start,
    output logic [RAW_W-1:0] nraw,
    output logic             skew_q,
    output logic [LEN_W-1:0] len_q,
    output logic             err,
    output logic             disp_on
);
    logic       take;
    logic       skew_in;
    logic       len_ok;
    logic       pwr_q;
    logic       first_q;

    // Screen the request and derive the raw byte count.
    always_comb begin
        take    = req_valid && !active;
        skew_in = is_skewed(req_cmd);
        len_ok  = (req_len != '0) &&
                  (!skew_in || (req_len == LEN_W'(3)) || (req_len == LEN_W'(4)));
        start   = take && len_ok;
        nraw    = RAW_W'(req_len) + (skew_in ? RAW_W'(1) : RAW_W'(0));
    end

    // Latch transaction mode, the error pulse and the panel-on flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skew_q  <= 1'b0;
            len_q   <= '0;
            err     <= 1'b0;
            pwr_q   <= 1'b0;
            first_q <= 1'b0;
            disp_on <= 1'b0;
        end else begin
            err <= take && !len_ok;
            if (start) begin
                skew_q  <= skew_in;
                len_q   <= req_len;
                pwr_q   <= (req_cmd == CMD_PWRMODE);
                first_q <= 1'b1;
            end else if (out_valid && first_q) begin
                first_q <= 1'b0;
                if (pwr_q) disp_on <= ((out_data & PWR_KEEP) == PWR_ON_VAL);
            end
        end
    end

    // R6/R7: a refusal never coincides with a running transaction.
    assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !active);
    // R8: the on flag only moves right after a delivered byte.
    assert_flag_moves_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_on) |-> $past(out_valid));

endmodule

// File: rtl/dbi_read_engine.sv
// Module: top of the serial display read engine.
// Combines rate tick, bit engine, realignment and request screening. Assumes
// one outstanding request; the data/command line stays low for the whole
// window since no parameter phase is written on a read.
module dbi_read_engine
    import dbi_rd_pkg::*;
#(
    parameter int unsigned SYS_HZ      = 125_000_000,
    parameter int unsigned LINK_MAX_HZ = 20_000_000,
    parameter int unsigned READ_CAP_HZ = 2_000_000,
    parameter int          LEN_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rd_last,
    output logic             err,
    output logic             done,
    output logic             disp_on,
    output logic             lnk_cs_n,
    output logic             lnk_sclk,
    output logic             lnk_dc,
    output logic             lnk_mosi,
    input  logic             lnk_miso
);
    localparam int unsigned HALF  = half_cycles(SYS_HZ, LINK_MAX_HZ, READ_CAP_HZ);
    localparam int          RAW_W = LEN_W + 1;
    localparam int          CNT_W = RAW_W + 4;

    logic             start;
    logic [RAW_W-1:0] nraw;
    logic             skew_q;
    logic [LEN_W-1:0] len_q;
    logic             active;
    logic             tick;
    logic             byte_stb;
    logic [7:0]       byte_data;

    dbi_rd_ctrl #(.LEN_W(LEN_W), .RAW_W(RAW_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_len(req_len), .active(active), .out_valid(rd_valid),
        .out_data(rd_data), .start(start), .nraw(nraw), .skew_q(skew_q),
        .len_q(len_q), .err(err), .disp_on(disp_on)
    );

    dbi_rd_clkgen #(.HALF(HALF)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .en(active), .tick(tick)
    );

    dbi_rd_serdes #(.RAW_W(RAW_W), .CNT_W(CNT_W)) u_serdes (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(req_cmd), .nraw(nraw),
        .tick(tick), .miso(lnk_miso), .active(active), .sclk(lnk_sclk),
        .mosi(lnk_mosi), .byte_stb(byte_stb), .byte_data(byte_data), .fin(done)
    );

    dbi_rd_align #(.LEN_W(LEN_W)) u_align (
        .clk(clk), .rst_n(rst_n), .clr(start), .skew(skew_q), .len(len_q),
        .in_stb(byte_stb), .in_data(byte_data), .out_valid(rd_valid),
        .out_data(rd_data), .out_last(rd_last)
    );

    assign busy     = active;
    assign lnk_cs_n = ~active;
    assign lnk_dc   = ~active;

    // R2: data/command select is low throughout the window.
    assert_dc_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_cs_n |-> !lnk_dc);
    // R1: the serial clock only changes on a rate tick.
    assert_sclk_paced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!lnk_cs_n && !tick) |=> $stable(lnk_sclk));
    // R9: done follows a busy cycle.
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

// File: tb/dbi_read_engine_bench.sv
module dbi_read_engine_bench;
    localparam int unsigned SYS_HZ = 125_000_000;
    localparam int unsigned LINK   = 25_000_000;
    localparam int unsigned CAP    = 15_625_000;
    localparam int          LW     = 4;
    // Read rate = min(15.625 MHz, 12.5 MHz) = 12.5 MHz -> 125/25 = 5 cycles.
    localparam int          EXP_HALF = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [7:0]    req_cmd = '0;
    logic [LW-1:0] req_len = '0;
    logic busy, rd_valid, rd_last, err, done, disp_on;
    logic [7:0] rd_data;
    logic cs_n, sclk, dc, mosi;
    logic miso = 1'b0;

    always #4 clk = ~clk;

    dbi_read_engine #(.SYS_HZ(SYS_HZ), .LINK_MAX_HZ(LINK), .READ_CAP_HZ(CAP),
                      .LEN_W(LW)) u_dbi_read_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_len(req_len), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .err(err), .done(done), .disp_on(disp_on),
        .lnk_cs_n(cs_n), .lnk_sclk(sclk), .lnk_dc(dc), .lnk_mosi(mosi),
        .lnk_miso(miso)
    );

    int nchecks = 0;
    int nfail = 0;
    bit finished = 0;

    // Panel model state
    logic [7:0] resp [0:31];
    int   plen = 0;
    bit   pskew = 0;
    int   rcnt = 0;
    logic [7:0] cap_cmd = '0;
    int   dc_bad = 0;
    int   hi_bad = 0;
    int   lo_bad = 0;
    realtime t_rise = 0, t_fall = 0;
    bit   seen_fall = 0;

    // Collector state
    logic [7:0] got [0:31];
    int   ng = 0;
    int   last_pos = -1;
    int   last_cnt = 0;
    bit   done_seen = 0;
    int   err_seen = 0;

    task automatic check(bit ok, string req, int act, int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic stream_bit(int j);
        int idx;
        if (pskew) begin
            if (j == 0) return 1'b1;
            idx = j - 1;
        end else idx = j;
        if (idx / 8 < plen) return resp[idx / 8][7 - (idx % 8)];
        return 1'b1;
    endfunction

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rcnt < 8) cap_cmd = {cap_cmd[6:0], mosi};
            if (dc) dc_bad++;
            if (seen_fall && (($realtime - t_fall) != EXP_HALF * 8.0)) lo_bad++;
            t_rise = $realtime;
            rcnt++;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (($realtime - t_rise) != EXP_HALF * 8.0) hi_bad++;
            t_fall = $realtime;
            seen_fall = 1;
            miso = (rcnt >= 8) ? stream_bit(rcnt - 8) : 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rd_valid && ng < 32) begin
            got[ng] = rd_data;
            if (rd_last) begin last_pos = ng; last_cnt++; end
            ng++;
        end
        if (done) done_seen = 1;
        if (err) err_seen++;
    end

    task automatic clear_obs();
        rcnt = 0; dc_bad = 0; hi_bad = 0; lo_bad = 0; seen_fall = 0;
        ng = 0; last_pos = -1; last_cnt = 0; done_seen = 0; err_seen = 0;
        cap_cmd = '0; miso = 1'b0;
    endtask

    // Good read: cmd, len, panel replies with resp[0..len-1]; optional intrusion.
    task automatic do_read(logic [7:0] cmd, int len, bit intrude);
        int wd;
        clear_obs();
        plen  = len;
        pskew = (cmd == 8'h04) || (cmd == 8'h09);
        @(negedge clk);
        req_valid = 1; req_cmd = cmd; req_len = LW'(len);
        @(negedge clk);
        req_valid = 0;
        check(busy == 1'b1, "R9 busy after accept", busy, 1);
        if (intrude) begin
            repeat (20) @(negedge clk);
            req_valid = 1; req_cmd = 8'h04; req_len = '0;
            @(negedge clk);
            req_valid = 0;
        end
        wd = 0;
        while (!done_seen && wd < 4000) begin @(negedge clk); wd++; end
        repeat (2) @(negedge clk);
        check(done_seen, "R9 done pulse", done_seen, 1);
        check(busy == 1'b0 && cs_n == 1'b1, "R9 idle after done", busy, 0);
        check(cap_cmd == cmd, "R2 command bits", cap_cmd, cmd);
        check(dc_bad == 0, "R2 dc low in window", dc_bad, 0);
        check(hi_bad == 0 && lo_bad == 0, "R1 clock phase length", hi_bad + lo_bad, 0);
        check(rcnt == 8 + 8 * (len + (pskew ? 1 : 0)), "R3 rising edge count",
              rcnt, 8 + 8 * (len + (pskew ? 1 : 0)));
        check(ng == len, pskew ? "R5 byte count" : "R4 byte count", ng, len);
        for (int i = 0; i < len && i < ng; i++)
            check(got[i] == resp[i], pskew ? "R5 realigned byte" : "R4 raw byte",
                  got[i], resp[i]);
        check(last_pos == len - 1 && last_cnt == 1, "R4 last marker", last_pos, len - 1);
        if (intrude) check(err_seen == 0, "R9 request while busy ignored", err_seen, 0);
    endtask

    task automatic do_reject(logic [7:0] cmd, int len, string req);
        clear_obs();
        @(negedge clk);
        req_valid = 1; req_cmd = cmd; req_len = LW'(len);
        @(negedge clk);
        req_valid = 0;
        check(err == 1'b1, req, err, 1);
        repeat (30) @(negedge clk);
        check(rcnt == 0 && busy == 0 && cs_n == 1, req, rcnt, 0);
        check(err_seen == 1, req, err_seen, 1);
    endtask

    task automatic pwr_read(logic [7:0] v, bit exp_on);
        resp[0] = v;
        do_read(8'h0A, 1, 0);
        check(disp_on == exp_on, "R8 panel-on flag", disp_on, exp_on);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++; nchecks++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] cmds [0:5];
        void'($urandom(32'd4242));
        cmds[0] = 8'h04; cmds[1] = 8'h09; cmds[2] = 8'h0A;
        cmds[3] = 8'h0B; cmds[4] = 8'h0C; cmds[5] = 8'h2E;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(cs_n == 1 && sclk == 0 && dc == 1, "R10 link idle", {cs_n, sclk, dc}, 3'b101);
        check(busy == 0 && rd_valid == 0 && err == 0 && done == 0 && disp_on == 0,
              "R10 flags low", {busy, rd_valid, err, done, disp_on}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Directed R4: plain read, pattern with alternating MSBs
        resp[0] = 8'hA5; resp[1] = 8'h3C;
        do_read(8'h0B, 2, 0);
        // Directed R5: identification, 3 bytes, MSBs that expose a missing shift
        resp[0] = 8'h80; resp[1] = 8'h01; resp[2] = 8'hFF;
        do_read(8'h04, 3, 0);
        // R5: status, 4 bytes
        resp[0] = 8'h12; resp[1] = 8'h9A; resp[2] = 8'h7F; resp[3] = 8'hC3;
        do_read(8'h09, 4, 0);
        // R6 wrong lengths on skewed commands
        do_reject(8'h04, 2, "R6 bad length ident");
        do_reject(8'h09, 5, "R6 bad length status");
        // R7 zero length
        do_reject(8'h0B, 0, "R7 zero length");
        // R8 power-mode decoding (reserved bits ignored, other bits count)
        pwr_read(8'h9F, 1'b1);
        pwr_read(8'h18, 1'b0);
        pwr_read(8'h1C, 1'b1);
        pwr_read(8'h3C, 1'b0);
        // R8: a non power-mode read leaves the flag alone
        resp[0] = 8'h00;
        do_read(8'h0B, 1, 0);
        check(disp_on == 1'b0, "R8 flag unchanged by other read", disp_on, 0);
        // R9 intrusion during a transaction
        resp[0] = 8'h55; resp[1] = 8'hAA; resp[2] = 8'h0F;
        do_read(8'h0C, 3, 1);
        // Random mix
        for (int t = 0; t < 14; t++) begin
            logic [7:0] c;
            int n;
            c = cmds[$urandom % 6];
            if (c == 8'h04 || c == 8'h09) n = 3 + ($urandom % 2);
            else n = 1 + ($urandom % 15);
            for (int i = 0; i < n; i++) resp[i] = 8'($urandom);
            do_read(c, n, 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

endmodule